// File: doc/BRIEF.md
# Multicast Ingress Network Interface

This block sits at one input of a mesh-based switch fabric. Fixed-size cells come in from the line card side. Each cell carries a destination bit mask with one bit per switch output and a payload word. Every accepted cell is held in one first-in first-out queue. The block then feeds the cell at the head of that queue into the first router of its mesh row. It sends only when the router has buffer space. Space is tracked with credits: the block starts with a credit for each buffer slot in the router, spends one per packet it sends, and gets one back on each return pulse.

A static mode input picks how a cell becomes packets. In copy mode, the cell is expanded into unicast packets, one for each destination bit, and each packet carries a one-hot mask. In multicast mode, the cell goes out once with its whole mask, and the routers downstream make the copies. Either way, each cell crosses the line-card boundary through a single handshake. A cell whose mask is all zeros has no destination, so it is discarded at the queue head. The mode input may change only while the block is empty.

Top module: `mc_ingress_ni`

## Requirements
- R1: Cells leave in the order they were accepted, in both modes, and are taken in with exactly one valid/ready handshake each.
- R2: `cell_ready_o` is low while the queue holds FIFO_DEPTH cells and high whenever it holds fewer.
- R3: A packet is sent only while a credit is held. With no credits returned, exactly RTR_CREDITS packets leave after reset, and sending resumes as credits come back.
- R4: In copy mode (`copy_mode_i` = 1), one packet leaves for each set mask bit. Bit k of the mask stands for output k. Each packet has exactly bit k set, and the packets leave in ascending k.
- R5: In copy mode with credits available, the copies of one cell leave on consecutive cycles. The cell stays at the head until its last copy is sent, so a credit stall in the middle of a cell resumes with that cell's remaining bits.
- R6: In multicast mode (`copy_mode_i` = 0), a cell leaves as a single packet carrying its unchanged mask.
- R7: A cell with an all-zero mask produces no packet in either mode, and the cell behind it is delivered normally.
- R8: After reset, `pkt_valid_o` is low, `cell_ready_o` is high and all RTR_CREDITS credits are held.
- R9: Every packet carries the payload of its cell unchanged, including every copy made in copy mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| copy_mode_i | input | 1 | 1: expand into unicast copies; 0: send the cell once with its full mask |
| cell_valid_i | input | 1 | A cell is offered |
| cell_ready_o | output | 1 | The queue can accept a cell |
| cell_mask_i | input | NUM_OUT | Destination mask; bit k selects output k |
| cell_data_i | input | PAYLOAD_W | Cell payload |
| pkt_valid_o | output | 1 | One packet is presented to the router this cycle |
| pkt_mask_o | output | NUM_OUT | Packet destination mask |
| pkt_data_o | output | PAYLOAD_W | Packet payload |
| rtr_credit_i | input | 1 | Pulse: the router freed one input buffer slot |

## Verification
The bench builds the block with NUM_OUT = 4, FIFO_DEPTH = 4, RTR_CREDITS = 2 and a 16-bit payload. With four outputs, the all-ones fanout and the ascending order of copies can be checked in full. Two credits are enough to keep copies flowing on back-to-back cycles, and few enough that holding back credits stalls a cell in the middle of its expansion. The shallow queue fills after four cells, so the ready-deassertion boundary and in-order draining after a stall can be reached with a short directed sequence.

// File: rtl/mc_ni_pkg.sv
package mc_ni_pkg;
  typedef enum logic {
    FWD_MCAST = 1'b0,
    FWD_COPY  = 1'b1
  } fwd_mode_e;
endpackage

// File: rtl/mc_ni_cell_fifo.sv
module mc_ni_cell_fifo #(
  parameter int WIDTH = 20,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_ptr] <= wr_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en_i) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en_i) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_en_i, rd_en_i})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data_o = mem[rd_ptr];
  assign empty_o   = (count == '0);
  assign full_o    = (count == CW'(DEPTH));

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    full_o |-> !wr_en_i);
  assert_no_underflow_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    empty_o |-> !rd_en_i);
endmodule

// File: rtl/mc_ni_credit_ctr.sv
module mc_ni_credit_ctr #(
  parameter int MAX_CREDITS = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic spend_i,
  input  logic refund_i,
  output logic avail_o
);
  localparam int CW = $clog2(MAX_CREDITS + 1);
  localparam logic [CW-1:0] FULL = CW'(MAX_CREDITS);

  logic [CW-1:0] credits;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      credits <= FULL;
    end else begin
      case ({spend_i, refund_i})
        2'b10:   credits <= credits - 1'b1;
        2'b01:   credits <= credits + 1'b1;
        default: credits <= credits;
      endcase
    end
  end

  assign avail_o = (credits != '0);

  assert_credit_bound_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (credits == FULL) |-> !(refund_i && !spend_i));
  assert_spend_needs_credit_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    spend_i |-> (credits != '0));
endmodule

// File: rtl/mc_ni_lowbit_pick.sv
module mc_ni_lowbit_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] pending_i,
  output logic [N-1:0] pick_o,
  output logic         last_o
);
  logic [N-1:0] rest;

  assign pick_o = pending_i & (~pending_i + {{(N-1){1'b0}}, 1'b1});
  assign rest   = pending_i & ~pick_o;
  assign last_o = (rest == '0);
endmodule

// File: rtl/mc_ingress_ni.sv
module mc_ingress_ni #(
  parameter int NUM_OUT     = 4,
  parameter int PAYLOAD_W   = 16,
  parameter int FIFO_DEPTH  = 4,
  parameter int RTR_CREDITS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 copy_mode_i,
  input  logic                 cell_valid_i,
  output logic                 cell_ready_o,
  input  logic [NUM_OUT-1:0]   cell_mask_i,
  input  logic [PAYLOAD_W-1:0] cell_data_i,
  output logic                 pkt_valid_o,
  output logic [NUM_OUT-1:0]   pkt_mask_o,
  output logic [PAYLOAD_W-1:0] pkt_data_o,
  input  logic                 rtr_credit_i
);
  import mc_ni_pkg::*;

  localparam int CELL_W = NUM_OUT + PAYLOAD_W;

  fwd_mode_e              mode;
  logic                   fifo_empty, fifo_full, push, pop;
  logic [CELL_W-1:0]      head;
  logic [NUM_OUT-1:0]     head_mask, sent_q, pending, pick;
  logic [PAYLOAD_W-1:0]   head_data;
  logic                   pick_last, credit_ok, emit;
  logic [NUM_OUT-1:0]     emit_mask;

  assign mode         = fwd_mode_e'(copy_mode_i);
  assign cell_ready_o = !fifo_full;
  assign push         = cell_valid_i && !fifo_full;

  mc_ni_cell_fifo #(.WIDTH(CELL_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (push),
    .wr_data_i ({cell_mask_i, cell_data_i}),
    .rd_en_i   (pop),
    .rd_data_o (head),
    .empty_o   (fifo_empty),
    .full_o    (fifo_full)
  );

  assign head_mask = head[CELL_W-1:PAYLOAD_W];
  assign head_data = head[PAYLOAD_W-1:0];
  assign pending   = head_mask & ~sent_q;

  mc_ni_lowbit_pick #(.N(NUM_OUT)) pick_i (
    .pending_i (pending),
    .pick_o    (pick),
    .last_o    (pick_last)
  );

  mc_ni_credit_ctr #(.MAX_CREDITS(RTR_CREDITS)) credit_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .spend_i  (emit),
    .refund_i (rtr_credit_i),
    .avail_o  (credit_ok)
  );

  // Head-of-queue dispatch: one packet per cycle at most.
  always_comb begin
    emit      = 1'b0;
    pop       = 1'b0;
    emit_mask = head_mask;
    if (!fifo_empty) begin
      if (mode == FWD_COPY) begin
        emit_mask = pick;
        if (pending == '0) begin
          pop = 1'b1;
        end else if (credit_ok) begin
          emit = 1'b1;
          pop  = pick_last;
        end
      end else begin
        if (head_mask == '0) begin
          pop = 1'b1;
        end else if (credit_ok) begin
          emit = 1'b1;
          pop  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sent_q      <= '0;
      pkt_valid_o <= 1'b0;
      pkt_mask_o  <= '0;
      pkt_data_o  <= '0;
    end else begin
      if (pop)       sent_q <= '0;
      else if (emit) sent_q <= sent_q | pick;
      pkt_valid_o <= emit;
      if (emit) begin
        pkt_mask_o <= emit_mask;
        pkt_data_o <= head_data;
      end
    end
  end

  assert_copy_onehot_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (pkt_valid_o && copy_mode_i) |-> ($countones(pkt_mask_o) == 1));
  assert_no_empty_packet_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    pkt_valid_o |-> (pkt_mask_o != '0));
endmodule

// File: tb/mc_ingress_ni_tb_top.sv
`timescale 1ns/1ps
module mc_ingress_ni_tb_top;
  localparam int N  = 4;
  localparam int PW = 16;
  localparam int FD = 4;
  localparam int CR = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic copy_mode = 1'b0, cell_valid = 1'b0, rtr_credit = 1'b0;
  logic [N-1:0]  cell_mask = '0;
  logic [PW-1:0] cell_data = '0;
  logic cell_ready, pkt_valid;
  logic [N-1:0]  pkt_mask;
  logic [PW-1:0] pkt_data;

  always #4 clk = ~clk;

  mc_ingress_ni #(.NUM_OUT(N), .PAYLOAD_W(PW), .FIFO_DEPTH(FD), .RTR_CREDITS(CR)) dut_i (
    .clk_i(clk), .rst_i(rst), .copy_mode_i(copy_mode),
    .cell_valid_i(cell_valid), .cell_ready_o(cell_ready),
    .cell_mask_i(cell_mask), .cell_data_i(cell_data),
    .pkt_valid_o(pkt_valid), .pkt_mask_o(pkt_mask), .pkt_data_o(pkt_data),
    .rtr_credit_i(rtr_credit));

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit ret_en = 1'b1;
  bit finished = 1'b0;

  logic [N-1:0]  got_mask [64];
  logic [PW-1:0] got_data [64];
  int            got_cyc  [64];
  int            got_n = 0;
  logic [N-1:0]  exp_mask [64];
  logic [PW-1:0] exp_data [64];
  int            exp_n = 0;

  // mode, mask, payload
  localparam logic [20:0] VEC [8] = '{
    {1'b1, 4'b1011, 16'hA001}, {1'b1, 4'b0001, 16'hA002},
    {1'b1, 4'b1000, 16'hA003}, {1'b1, 4'b1111, 16'hA004},
    {1'b0, 4'b1011, 16'hB001}, {1'b0, 4'b0001, 16'hB002},
    {1'b0, 4'b1111, 16'hB003}, {1'b1, 4'b0110, 16'hA005}};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Monitor and router credit model, both at the falling edge.
  initial begin
    int pend = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (pkt_valid) begin
        if (got_n < 64) begin
          got_mask[got_n] = pkt_mask;
          got_data[got_n] = pkt_data;
          got_cyc[got_n]  = cyc;
        end
        got_n++;
        pend++;
      end
      if (ret_en && pend > 0) begin
        rtr_credit = 1'b1;
        pend--;
      end else begin
        rtr_credit = 1'b0;
      end
    end
  end

  task automatic expect_cell(input bit cp, input logic [N-1:0] m, input logic [PW-1:0] d);
    if (m == '0) return;
    if (cp) begin
      for (int k = 0; k < N; k++) begin
        if (m[k]) begin
          exp_mask[exp_n] = N'(1) << k;
          exp_data[exp_n] = d;
          exp_n++;
        end
      end
    end else begin
      exp_mask[exp_n] = m;
      exp_data[exp_n] = d;
      exp_n++;
    end
  endtask

  task automatic push(input logic [N-1:0] m, input logic [PW-1:0] d);
    @(negedge clk);
    while (!cell_ready) @(negedge clk);
    cell_valid = 1'b1;
    cell_mask  = m;
    cell_data  = d;
    @(negedge clk);
    cell_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic compare(input string req, input bit back_to_back);
    check(got_n == exp_n, req, "packet count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check(got_mask[i] == exp_mask[i], req, "mask (R4/R6 order and shape)",
            int'(got_mask[i]), int'(exp_mask[i]));
      check(got_data[i] == exp_data[i], "R9", "payload", int'(got_data[i]), int'(exp_data[i]));
      if (back_to_back && i > 0)
        check(got_cyc[i] == got_cyc[i-1] + 1, "R5", "copy spacing",
              got_cyc[i] - got_cyc[i-1], 1);
    end
    got_n = 0;
    exp_n = 0;
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    // R8: reset state
    check(pkt_valid == 1'b0, "R8", "pkt_valid after reset", int'(pkt_valid), 0);
    check(cell_ready == 1'b1, "R8", "cell_ready after reset", int'(cell_ready), 1);

    // R3/R8/R2/R5: credits withheld, expansion stalls mid-cell, queue fills
    ret_en = 1'b0;
    copy_mode = 1'b1;
    push(4'b1111, 16'hC0DE);
    idle(6);
    check(got_n == CR, "R3", "packets sent without credit return", got_n, CR);
    push(4'b0001, 16'hD001);
    push(4'b0010, 16'hD002);
    check(cell_ready == 1'b1, "R2", "ready with FIFO_DEPTH-1 cells", int'(cell_ready), 1);
    push(4'b0100, 16'hD003);
    check(cell_ready == 1'b0, "R2", "ready with FIFO_DEPTH cells", int'(cell_ready), 0);
    idle(3);
    check(got_n == CR, "R3", "no packet while out of credit", got_n, CR);
    ret_en = 1'b1;
    idle(20);
    check(cell_ready == 1'b1, "R2", "ready after drain", int'(cell_ready), 1);
    expect_cell(1'b1, 4'b1111, 16'hC0DE);
    expect_cell(1'b1, 4'b0001, 16'hD001);
    expect_cell(1'b1, 4'b0010, 16'hD002);
    expect_cell(1'b1, 4'b0100, 16'hD003);
    compare("R1", 1'b0);

    // Table of single cells, both modes
    for (int v = 0; v < 8; v++) begin
      copy_mode = VEC[v][20];
      push(VEC[v][19:16], VEC[v][15:0]);
      idle(12);
      expect_cell(VEC[v][20], VEC[v][19:16], VEC[v][15:0]);
      compare(VEC[v][20] ? "R4" : "R6", VEC[v][20]);
    end

    // R7: zero mask dropped, follower delivered (multicast, then copy)
    copy_mode = 1'b0;
    push(4'b0000, 16'hE000);
    push(4'b0101, 16'hE001);
    idle(10);
    expect_cell(1'b0, 4'b0101, 16'hE001);
    compare("R7", 1'b0);
    copy_mode = 1'b1;
    push(4'b0000, 16'hE100);
    push(4'b0110, 16'hE101);
    idle(10);
    expect_cell(1'b1, 4'b0110, 16'hE101);
    compare("R7", 1'b1);

    // R1: back-to-back mixed cells in multicast mode keep order
    copy_mode = 1'b0;
    push(4'b1100, 16'hF001);
    push(4'b0011, 16'hF002);
    push(4'b1001, 16'hF003);
    idle(12);
    expect_cell(1'b0, 4'b1100, 16'hF001);
    expect_cell(1'b0, 4'b0011, 16'hF002);
    expect_cell(1'b0, 4'b1001, 16'hF003);
    compare("R1", 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule